// File: doc/BRIEF.md
# Control Register Access Legality Checker

This block decides, in the same cycle, whether an instruction that reads or writes a control/status register may proceed. The decode stage presents the 12-bit register number, the hart's current privilege, whether the access writes, and a few configuration and status bits. The block answers with a single flag. When the flag is low, the core raises an illegal-instruction exception instead of touching the register.

Legality combines several independent rules, and all of them must agree:
- the register number must name an implemented register;
- registers whose top two address bits are set may not be written;
- the current privilege must reach the minimum privilege encoded in the address;
- the address-translation register may be locked away from supervisor code;
- the user-visible cycle, time and retired-instruction counters are gated by enable bits held at machine and supervisor level.

The block contains no storage and no clock. The registers themselves live elsewhere.

Top module: `csr_access_checker`

## Requirements
- R1: A write is illegal to any address whose bits [11:10] equal 2'b11, whatever the other inputs are.
- R2: An access is illegal when the privilege input, taken as an unsigned number, is below address bits [9:8]. The privilege codes are user 2'b00, supervisor 2'b01 and machine 2'b11.
- R3: Any address outside the implemented set is illegal. The always-present set is:
  - 0xF11–0xF14;
  - 0x300–0x306 and 0x340–0x344;
  - 0x3A0 and 0x3A2;
  - 0x3B0–0x3BF;
  - 0xB00 and 0xB02;
  - 0x7A0;
  - 0xC00–0xC02.
- R4: The addresses 0x3A1, 0x3A3, 0xB80, 0xB82 and 0xC80–0xC82 are implemented only when `xlen_is_32` is high.
- R5: The addresses 0x100, 0x102–0x106, 0x140–0x144 and 0x180 are implemented only when `has_smode` is high. Address 0x101 is never implemented.
- R6: An access to 0x180 at supervisor privilege is illegal while `tvm` is high. The same access at machine privilege is unaffected.
- R7: At supervisor privilege, an access to 0xC00, 0xC01 or 0xC02 needs bit 0, 1 or 2 of `mcnt_en` respectively. At machine privilege, the counter enables have no effect.
- R8: At user privilege, the same counters need the matching `mcnt_en` bit. When `has_smode` is high, they also need the matching `scnt_en` bit. When `has_smode` is low, `scnt_en` has no effect.
- R9: Addresses 0xC03 through 0xC1F are illegal at every privilege.
- R10: The reserved privilege code 2'b10 makes every access illegal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| csr_addr | input | 12 | Register number of the access |
| cur_priv | input | 2 | Current privilege (U=00, S=01, M=11) |
| is_write | input | 1 | High when the access writes the register |
| has_smode | input | 1 | Strap: supervisor privilege implemented |
| xlen_is_32 | input | 1 | Strap: 32-bit register width, enabling high-half registers |
| tvm | input | 1 | Trap-virtual-memory status bit |
| mcnt_en | input | 3 | Machine counter enables: bit0 cycle, bit1 time, bit2 instret |
| scnt_en | input | 3 | Supervisor counter enables, same bit order |
| access_ok | output | 1 | High when the access is legal |

## Verification
The verdict is purely combinational, so every result is due zero cycles after its inputs change. The bench drives a new vector just after each falling clock edge and samples `access_ok` 2 ns later, well before the next rising edge. This leaves room for every gate level to settle and removes any dependence on the order of processes at the edge.

Stimulus has two parts:
- a full sweep of all 4096 addresses for each legal privilege and for both reads and writes, with random straps and enables drawn from a fixed seed;
- directed vectors for the translation-lock, counter-chaining, width-strap and reserved-privilege corners.

Every vector is compared against a bench function that restates the rules with its own range arithmetic.

// File: rtl/csr_chk_pkg.sv
package csr_chk_pkg;

  localparam int ADDR_W = 12;
  localparam int PRIV_W = 2;

  typedef enum logic [PRIV_W-1:0] {
    PRIV_U    = 2'b00,
    PRIV_S    = 2'b01,
    PRIV_RSVD = 2'b10,
    PRIV_M    = 2'b11
  } priv_e;

  localparam logic [ADDR_W-1:0] ADDR_SATP     = 12'h180;
  localparam logic [ADDR_W-1:0] ADDR_UCNT_LO  = 12'hC00;
  localparam logic [ADDR_W-1:0] ADDR_UCNT_TOP = 12'hC1F;

  // Registers present in every configuration.
  function automatic logic addr_always_present(input logic [ADDR_W-1:0] a);
    logic hit;
    hit = 1'b0;
    case (a) inside
      [12'hF11:12'hF14]: hit = 1'b1;
      [12'h300:12'h306]: hit = 1'b1;
      [12'h340:12'h344]: hit = 1'b1;
      12'h3A0, 12'h3A2:  hit = 1'b1;
      [12'h3B0:12'h3BF]: hit = 1'b1;
      12'hB00, 12'hB02:  hit = 1'b1;
      12'h7A0:           hit = 1'b1;
      [12'hC00:12'hC02]: hit = 1'b1;
      default:           hit = 1'b0;
    endcase
    return hit;
  endfunction

  // Upper-half registers that exist only with a 32-bit register width.
  function automatic logic addr_narrow_only(input logic [ADDR_W-1:0] a);
    logic hit;
    hit = 1'b0;
    case (a) inside
      12'h3A1, 12'h3A3:  hit = 1'b1;
      12'hB80, 12'hB82:  hit = 1'b1;
      [12'hC80:12'hC82]: hit = 1'b1;
      default:           hit = 1'b0;
    endcase
    return hit;
  endfunction

  // Supervisor-level registers.
  function automatic logic addr_super_only(input logic [ADDR_W-1:0] a);
    logic hit;
    hit = 1'b0;
    case (a) inside
      12'h100:           hit = 1'b1;
      [12'h102:12'h106]: hit = 1'b1;
      [12'h140:12'h144]: hit = 1'b1;
      12'h180:           hit = 1'b1;
      default:           hit = 1'b0;
    endcase
    return hit;
  endfunction

  function automatic logic addr_read_only(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: 2] == 2'b11;
  endfunction

  function automatic logic [PRIV_W-1:0] addr_min_priv(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-3 -: PRIV_W];
  endfunction

  function automatic logic priv_reaches(input logic [PRIV_W-1:0] p,
                                        input logic [PRIV_W-1:0] need);
    return p >= need;
  endfunction

endpackage

// File: rtl/csr_addr_table.sv
module csr_addr_table
  import csr_chk_pkg::*;
(
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic              has_smode,
  input  logic              xlen_is_32,
  output logic              defined
);
  logic base_hit;
  logic narrow_hit;
  logic super_hit;

  always_comb begin
    base_hit   = addr_always_present(csr_addr);
    narrow_hit = addr_narrow_only(csr_addr) & xlen_is_32;
    super_hit  = addr_super_only(csr_addr) & has_smode;
    defined    = base_hit | narrow_hit | super_hit;
  end
endmodule

// File: rtl/csr_field_rules.sv
module csr_field_rules
  import csr_chk_pkg::*;
(
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic [PRIV_W-1:0] cur_priv,
  input  logic              is_write,
  input  logic              tvm,
  output logic              ro_violation,
  output logic              priv_violation,
  output logic              tvm_violation,
  output logic              priv_reserved
);
  always_comb begin
    ro_violation   = is_write & addr_read_only(csr_addr);
    priv_violation = !priv_reaches(cur_priv, addr_min_priv(csr_addr));
    tvm_violation  = tvm & (cur_priv == PRIV_S) & (csr_addr == ADDR_SATP);
    priv_reserved  = (cur_priv == PRIV_RSVD);
  end
endmodule

// File: rtl/csr_counter_gate.sv
module csr_counter_gate
  import csr_chk_pkg::*;
#(
  parameter int NUM_CNT = 3
) (
  input  logic [ADDR_W-1:0]  csr_addr,
  input  logic [PRIV_W-1:0]  cur_priv,
  input  logic               has_smode,
  input  logic [NUM_CNT-1:0] mcnt_en,
  input  logic [NUM_CNT-1:0] scnt_en,
  output logic               cnt_blocked,
  output logic               hpm_hit
);
  localparam logic [ADDR_W-1:0] HPM_LO = ADDR_UCNT_LO + ADDR_W'(NUM_CNT);

  logic [NUM_CNT-1:0] cnt_hit;
  logic [NUM_CNT-1:0] cnt_allow;

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    always_comb begin
      cnt_hit[i] = (csr_addr == ADDR_UCNT_LO + ADDR_W'(i));
      unique case (cur_priv)
        PRIV_M:  cnt_allow[i] = 1'b1;
        PRIV_S:  cnt_allow[i] = mcnt_en[i];
        PRIV_U:  cnt_allow[i] = mcnt_en[i] & (!has_smode | scnt_en[i]);
        default: cnt_allow[i] = 1'b0;
      endcase
    end
  end

  always_comb begin
    cnt_blocked = |(cnt_hit & ~cnt_allow);
    hpm_hit     = (csr_addr >= HPM_LO) && (csr_addr <= ADDR_UCNT_TOP);
  end
endmodule

// File: rtl/csr_access_checker.sv
module csr_access_checker
  import csr_chk_pkg::*;
#(
  parameter int NUM_CNT = 3
) (
  input  logic [11:0]        csr_addr,
  input  logic [1:0]         cur_priv,
  input  logic               is_write,
  input  logic               has_smode,
  input  logic               xlen_is_32,
  input  logic               tvm,
  input  logic [NUM_CNT-1:0] mcnt_en,
  input  logic [NUM_CNT-1:0] scnt_en,
  output logic               access_ok
);
  // Named intermediate verdicts, visible to the bound checker.
  logic addr_defined;
  logic ro_violation;
  logic priv_violation;
  logic tvm_violation;
  logic priv_reserved;
  logic cnt_blocked;
  logic hpm_hit;

  csr_addr_table u_table (
    .csr_addr   (csr_addr),
    .has_smode  (has_smode),
    .xlen_is_32 (xlen_is_32),
    .defined    (addr_defined)
  );

  csr_field_rules u_fields (
    .csr_addr       (csr_addr),
    .cur_priv       (cur_priv),
    .is_write       (is_write),
    .tvm            (tvm),
    .ro_violation   (ro_violation),
    .priv_violation (priv_violation),
    .tvm_violation  (tvm_violation),
    .priv_reserved  (priv_reserved)
  );

  csr_counter_gate #(.NUM_CNT(NUM_CNT)) u_cnt (
    .csr_addr    (csr_addr),
    .cur_priv    (cur_priv),
    .has_smode   (has_smode),
    .mcnt_en     (mcnt_en),
    .scnt_en     (scnt_en),
    .cnt_blocked (cnt_blocked),
    .hpm_hit     (hpm_hit)
  );

  always_comb begin
    access_ok = addr_defined & !ro_violation & !priv_violation & !tvm_violation
              & !priv_reserved & !cnt_blocked & !hpm_hit;
  end
endmodule

// File: rtl/csr_access_checker_sva.sv
module csr_access_checker_sva #(
  parameter int NUM_CNT = 3
) (
  input logic [11:0]        csr_addr,
  input logic [1:0]         cur_priv,
  input logic               is_write,
  input logic               tvm,
  input logic [NUM_CNT-1:0] mcnt_en,
  input logic               addr_defined,
  input logic               access_ok
);
  logic known;

  always_comb begin
    known = !$isunknown({csr_addr, cur_priv, is_write, tvm, mcnt_en, addr_defined, access_ok});
    if (known) begin
      assert_ro_write_R1: assert (!(is_write && csr_addr[11:10] == 2'b11) || !access_ok);
      assert_low_priv_R2: assert (!(cur_priv < csr_addr[9:8]) || !access_ok);
      assert_undefined_R3: assert (addr_defined || !access_ok);
      assert_satp_lock_R6: assert (!(tvm && cur_priv == 2'b01 && csr_addr == 12'h180) || !access_ok);
      assert_s_counter_R7: assert (!(cur_priv == 2'b01 && csr_addr == 12'hC00 && !mcnt_en[0]) || !access_ok);
      assert_hpm_R9: assert (!(csr_addr >= 12'hC03 && csr_addr <= 12'hC1F) || !access_ok);
      assert_rsvd_priv_R10: assert (cur_priv != 2'b10 || !access_ok);
    end
  end
endmodule

bind csr_access_checker csr_access_checker_sva #(.NUM_CNT(NUM_CNT)) u_sva (
  .csr_addr     (csr_addr),
  .cur_priv     (cur_priv),
  .is_write     (is_write),
  .tvm          (tvm),
  .mcnt_en      (mcnt_en),
  .addr_defined (addr_defined),
  .access_ok    (access_ok)
);

// File: tb/csr_access_checker_tb.sv
module csr_access_checker_tb;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic [11:0] csr_addr = '0;
  logic [1:0]  cur_priv = '0;
  logic        is_write = 1'b0;
  logic        has_smode = 1'b0;
  logic        xlen_is_32 = 1'b0;
  logic        tvm = 1'b0;
  logic [2:0]  mcnt_en = '0;
  logic [2:0]  scnt_en = '0;
  logic        access_ok;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  csr_access_checker u_dut (
    .csr_addr   (csr_addr),
    .cur_priv   (cur_priv),
    .is_write   (is_write),
    .has_smode  (has_smode),
    .xlen_is_32 (xlen_is_32),
    .tvm        (tvm),
    .mcnt_en    (mcnt_en),
    .scnt_en    (scnt_en),
    .access_ok  (access_ok)
  );

  // Reference: rules restated with range arithmetic.
  function automatic bit ref_defined(input logic [11:0] a, input bit s, input bit n32);
    bit d = 0;
    if (a >= 12'hF11 && a <= 12'hF14) d = 1;
    if (a[11:4] == 8'h30 && a[3:0] <= 4'h6) d = 1;
    if (a[11:4] == 8'h34 && a[3:0] <= 4'h4) d = 1;
    if (a[11:4] == 8'h3B) d = 1;
    if (a[11:2] == 10'b0011_1010_00 && a[0] == 1'b0) d = 1;
    if (a[11:2] == 10'b1011_0000_00 && a[0] == 1'b0) d = 1;
    if (a == 12'h7A0) d = 1;
    if (a[11:2] == 10'b1100_0000_00 && a[1:0] != 2'b11) d = 1;
    if (n32) begin
      if (a[11:2] == 10'b0011_1010_00 && a[0] == 1'b1) d = 1;
      if (a[11:2] == 10'b1011_1000_00 && a[0] == 1'b0) d = 1;
      if (a[11:2] == 10'b1100_1000_00 && a[1:0] != 2'b11) d = 1;
    end
    if (s) begin
      if (a[11:4] == 8'h10 && a[3:0] <= 4'h6 && a[3:0] != 4'h1) d = 1;
      if (a[11:4] == 8'h14 && a[3:0] <= 4'h4) d = 1;
      if (a == 12'h180) d = 1;
    end
    return d;
  endfunction

  function automatic bit ref_ok(input logic [11:0] a, input logic [1:0] p, input bit w,
                                input bit s, input bit n32, input bit t,
                                input logic [2:0] m, input logic [2:0] sc);
    int idx;
    if (p == 2'b10) return 0;
    if (!ref_defined(a, s, n32)) return 0;
    if (w && a[11] && a[10]) return 0;
    if (int'(p) < int'(a[9:8])) return 0;
    if (t && p == 2'b01 && a == 12'h180) return 0;
    if (a >= 12'hC03 && a <= 12'hC1F) return 0;
    idx = int'(a) - 'hC00;
    if (idx >= 0 && idx < 3) begin
      if (p == 2'b01 && !m[idx]) return 0;
      if (p == 2'b00 && (!m[idx] || (s && !sc[idx]))) return 0;
    end
    return 1;
  endfunction

  function automatic string tag_of(input logic [11:0] a, input logic [1:0] p, input bit w);
    if (p == 2'b10) return "R10";
    if (a >= 12'hC00 && a <= 12'hC02) return (p == 2'b01) ? "R7" : "R8";
    if (a >= 12'hC03 && a <= 12'hC1F) return "R9";
    if (a == 12'h180) return "R6";
    if (w && a[11:10] == 2'b11) return "R1";
    if (a[9:8] > p) return "R2";
    if (a[11:8] == 4'h1) return "R5";
    if (a == 12'h3A1 || a == 12'h3A3 || a[11:4] == 8'hB8 || a[11:4] == 8'hC8) return "R4";
    return "R3";
  endfunction

  task automatic apply(input logic [11:0] a, input logic [1:0] p, input bit w, input bit s,
                       input bit n32, input bit t, input logic [2:0] m, input logic [2:0] sc,
                       input string tag);
    bit exp;
    @(negedge clk);
    csr_addr = a; cur_priv = p; is_write = w; has_smode = s;
    xlen_is_32 = n32; tvm = t; mcnt_en = m; scnt_en = sc;
    #2;
    exp = ref_ok(a, p, w, s, n32, t, m, sc);
    n_vec++;
    if (access_ok !== exp) begin
      n_bad++;
      $display("FAIL %s addr=%h priv=%b wr=%b s=%b x32=%b tvm=%b m=%b s_en=%b: got %b expected %b",
               tag, a, p, w, s, n32, t, m, sc, access_ok, exp);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1D5E_ED01));
    // Idle inputs: user read of address 0 (undefined)
    apply(12'h000, 2'b00, 0, 0, 0, 0, 3'b000, 3'b000, "R3");
    // Directed corners
    apply(12'hF11, 2'b11, 1, 1, 1, 0, 3'b111, 3'b111, "R1");
    apply(12'hF11, 2'b11, 0, 1, 1, 0, 3'b111, 3'b111, "R1");
    apply(12'h300, 2'b01, 0, 1, 1, 0, 3'b111, 3'b111, "R2");
    apply(12'h300, 2'b11, 1, 1, 1, 0, 3'b111, 3'b111, "R2");
    apply(12'h301, 2'b11, 0, 0, 0, 0, 3'b000, 3'b000, "R3");
    apply(12'h307, 2'b11, 0, 0, 0, 0, 3'b000, 3'b000, "R3");
    apply(12'hB80, 2'b11, 0, 0, 0, 0, 3'b000, 3'b000, "R4");
    apply(12'hB80, 2'b11, 0, 0, 1, 0, 3'b000, 3'b000, "R4");
    apply(12'hC81, 2'b00, 0, 0, 1, 0, 3'b000, 3'b000, "R4");
    apply(12'h105, 2'b01, 1, 0, 0, 0, 3'b000, 3'b000, "R5");
    apply(12'h105, 2'b01, 1, 1, 0, 0, 3'b000, 3'b000, "R5");
    apply(12'h101, 2'b11, 0, 1, 0, 0, 3'b000, 3'b000, "R5");
    apply(12'h180, 2'b01, 1, 1, 0, 1, 3'b000, 3'b000, "R6");
    apply(12'h180, 2'b01, 1, 1, 0, 0, 3'b000, 3'b000, "R6");
    apply(12'h180, 2'b11, 1, 1, 0, 1, 3'b000, 3'b000, "R6");
    apply(12'hC01, 2'b01, 0, 1, 0, 0, 3'b101, 3'b111, "R7");
    apply(12'hC01, 2'b01, 0, 1, 0, 0, 3'b010, 3'b000, "R7");
    apply(12'hC02, 2'b11, 0, 1, 0, 0, 3'b000, 3'b000, "R7");
    apply(12'hC02, 2'b00, 0, 1, 0, 0, 3'b100, 3'b000, "R8");
    apply(12'hC02, 2'b00, 0, 1, 0, 0, 3'b100, 3'b100, "R8");
    apply(12'hC02, 2'b00, 0, 0, 0, 0, 3'b100, 3'b000, "R8");
    apply(12'hC00, 2'b00, 0, 0, 0, 0, 3'b110, 3'b111, "R8");
    apply(12'hC03, 2'b11, 0, 1, 1, 0, 3'b111, 3'b111, "R9");
    apply(12'hC1F, 2'b00, 0, 1, 1, 0, 3'b111, 3'b111, "R9");
    apply(12'hC20, 2'b00, 0, 1, 1, 0, 3'b111, 3'b111, "R9");
    apply(12'hF14, 2'b10, 0, 1, 1, 0, 3'b111, 3'b111, "R10");
    apply(12'hC00, 2'b10, 0, 1, 1, 0, 3'b111, 3'b111, "R10");
    // Full sweep with random straps and enables
    for (int pi = 0; pi < 3; pi++) begin
      for (int w = 0; w < 2; w++) begin
        for (int a = 0; a < 4096; a++) begin
          logic [1:0] p;
          logic [11:0] ad;
          logic [31:0] r;
          p  = (pi == 2) ? 2'b11 : 2'(pi);
          ad = 12'(a);
          r  = $urandom;
          apply(ad, p, w[0], r[0], r[1], r[2], r[5:3], r[8:6], tag_of(ad, p, w[0]));
        end
      end
    end
    // Random reserved-privilege vectors
    for (int k = 0; k < 200; k++) begin
      logic [31:0] r;
      r = $urandom;
      apply(r[11:0], 2'b10, r[12], r[13], r[14], r[15], r[18:16], r[21:19], "R10");
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule